// File: doc/BRIEF.md
# Stepped Digital Volume Controller

This block turns a slow, edge-driven volume interface into a 16-level gain setting for a stereo output stage. A host drives three lines into it: a step strobe, a direction level and a shutdown level. Each qualified rising edge of the strobe moves the gain one 3 dB step up or down. The direction line picks which way. Both audio channels use the single setting that the block holds.

All three external lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer. The step strobe can also pass through an optional stability filter. This filter rejects glitches that a slowly rising or falling edge may cause.

The block drives three outputs. The gain index is a 4-bit code. The same setting also appears as a signed gain in dB. An output-enable flag is low while shutdown holds the stage muted. The stored gain stays unchanged across a shutdown, so the stage comes back at the level it had before.

Top module: `stepped_volume_ctrl`

## Requirements
- R1: After reset, the gain index is 11 and the dB output is 0.
- R2: A rising edge of the step strobe with the direction line high raises the index by one.
- R3: A rising edge of the step strobe with the direction line low lowers the index by one.
- R4: A steady level or a falling edge on the step strobe leaves the index unchanged. Toggling the direction line while the strobe stays high also leaves it unchanged. One rising edge produces at most one step.
- R5: An up step at index 15 leaves the index at 15.
- R6: A down step at index 0 leaves the index at 0.
- R7: The dB output is a signed 7-bit two's-complement value equal to index*3 - 33. It reads +12 at index 15 and -33 at index 0, and it changes on the same clock edge as the index.
- R8: While the shutdown line is high, the output enable is 0 (muted). Once the line returns low, the enable goes back to 1.
- R9: Strobe edges that arrive during shutdown are ignored. On leaving shutdown, the index is the value it had before shutdown.
- R10: The index never changes by more than one in a single clock cycle.
- R11: With the stability filter enabled, a strobe pulse shorter than DEBOUNCE_CYCLES system cycles causes no step. A pulse held longer than that causes exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| stepClkIn | input | 1 | Asynchronous step strobe; a rising edge requests one step |
| dirIn | input | 1 | Asynchronous direction level: 1 = up, 0 = down |
| shutdownIn | input | 1 | Asynchronous shutdown level: 1 = mute and freeze the gain |
| gainIdx | output | 4 | Gain index, 0 = -33 dB, 15 = +12 dB |
| gainDb | output | 7 | Signed gain in dB |
| outEnable | output | 1 | 1 = output stage enabled, 0 = muted |

## Verification
The embedded assertions check the per-cycle rules on every clock:
- the index moves at most one step per cycle and never wraps at either end;
- the dB output moves by exactly 3 whenever the index moves by one;
- no step command is issued in two back-to-back cycles;
- the index is frozen while a mute command is active.

Other behaviours only the directed scenarios can show, because they depend on input history. These are:
- the power-on value;
- the direction chosen at each edge;
- keeping the pre-shutdown setting;
- rejecting short strobe glitches through the filter.

// File: rtl/vol_pkg.sv
package vol_pkg;

  // Command strobes handed from control to the datapath each cycle
  typedef struct packed {
    logic up;    // raise the gain one step
    logic down;  // lower the gain one step
    logic mute;  // stage muted, gain frozen
  } stepCmd_t;

endpackage

// File: rtl/vol_sync.sv
// Plain two-flop synchronizer, one lane per bit
module vol_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/vol_debounce.sv
// Level filter: the output follows the input only after the input has held
// a different value for CYCLES consecutive clocks.
module vol_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawLvl,
  output logic cleanLvl
);

  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen   <= '0;
      cleanLvl <= 1'b0;
    end else if (rawLvl == cleanLvl) begin
      runLen <= '0;
    end else if (runLen == LAST) begin
      cleanLvl <= rawLvl;
      runLen   <= '0;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

  // The filtered level cannot flip twice in a row: every flip is followed
  // by at least CYCLES stable clocks.
  AST_DEB_NO_CHATTER: assert property (@(posedge clk) disable iff (!rst_n)
    (cleanLvl != $past(cleanLvl)) |=> $stable(cleanLvl)); // R11

endmodule

// File: rtl/vol_ctrl.sv
// Control: rising-edge detection on the filtered strobe, direction
// qualification and shutdown gating.
module vol_ctrl
  import vol_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     stepLvl,
  input  logic     dirLvl,
  input  logic     shdnLvl,
  output stepCmd_t cmd
);

  logic stepPrev;
  logic stepRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stepPrev <= 1'b0;
    else        stepPrev <= stepLvl;
  end

  // The edge is tracked even during shutdown, so a strobe that is still
  // high when shutdown ends does not count as a new edge.
  assign stepRise = stepLvl & ~stepPrev;

  always_comb begin
    cmd.mute = shdnLvl;
    cmd.up   = stepRise &  dirLvl & ~shdnLvl;
    cmd.down = stepRise & ~dirLvl & ~shdnLvl;
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.up, cmd.down})); // R2

  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.up || cmd.down) |=> !(cmd.up || cmd.down)); // R4

endmodule

// File: rtl/vol_datapath.sv
// Datapath: saturating gain index, dB conversion and enable flag.
module vol_datapath
  import vol_pkg::*;
#(
  parameter int LEVELS      = 16,
  parameter int STEP_DB     = 3,
  parameter int MIN_DB      = -33,
  parameter int DEFAULT_IDX = 11,
  parameter int DB_W        = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  stepCmd_t               cmd,
  output logic [$clog2(LEVELS)-1:0] gainIdx,
  output logic signed [DB_W-1:0] gainDb,
  output logic                   outEnable
);

  localparam int IDX_W = $clog2(LEVELS);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(LEVELS - 1);
  localparam logic [IDX_W-1:0] INIT_IDX = IDX_W'(DEFAULT_IDX);

  function automatic logic signed [DB_W-1:0] idxToDb(input logic [IDX_W-1:0] i);
    int v;
    v = int'(i) * STEP_DB + MIN_DB;
    return DB_W'(v);
  endfunction

  localparam logic signed [DB_W-1:0] INIT_DB = idxToDb(INIT_IDX);

  logic [IDX_W-1:0] idxNext;

  always_comb begin
    idxNext = gainIdx;
    if (cmd.up && gainIdx != TOP_IDX)        idxNext = gainIdx + 1'b1;
    else if (cmd.down && gainIdx != '0)      idxNext = gainIdx - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gainIdx   <= INIT_IDX;
      gainDb    <= INIT_DB;
      outEnable <= 1'b0;
    end else begin
      gainIdx   <= idxNext;
      gainDb    <= idxToDb(idxNext);
      outEnable <= ~cmd.mute;
    end
  end

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gainIdx) - int'($past(gainIdx)) <= 1) &&
    (int'($past(gainIdx)) - int'(gainIdx) <= 1)); // R10

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (gainIdx == TOP_IDX) |=> (gainIdx != '0)); // R5

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (gainIdx == '0) |=> (gainIdx != TOP_IDX)); // R6

  AST_DB_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(gainIdx) == int'($past(gainIdx)) + 1) |->
      (int'(gainDb) == int'($past(gainDb)) + STEP_DB)); // R7

  AST_FROZEN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.mute |=> $stable(gainIdx)); // R9

  AST_MUTE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.mute |=> !outEnable); // R8

endmodule

// File: rtl/stepped_volume_ctrl.sv
// Thin top: synchronizers, optional strobe filter, control and datapath.
module stepped_volume_ctrl
  import vol_pkg::*;
#(
  parameter int LEVELS          = 16,
  parameter int STEP_DB         = 3,
  parameter int MIN_DB          = -33,
  parameter int DEFAULT_IDX     = 11,
  parameter int DB_W            = 7,
  parameter bit DEBOUNCE_EN     = 1'b1,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stepClkIn,
  input  logic                      dirIn,
  input  logic                      shutdownIn,
  output logic [$clog2(LEVELS)-1:0] gainIdx,
  output logic signed [DB_W-1:0]    gainDb,
  output logic                      outEnable
);

  logic [2:0] syncBus;
  logic       stepSync;
  logic       stepClean;
  stepCmd_t   cmd;

  vol_sync #(.WIDTH(3)) uSync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({shutdownIn, dirIn, stepClkIn}),
    .syncOut (syncBus)
  );

  assign stepSync = syncBus[0];

  generate
    if (DEBOUNCE_EN) begin : gFilter
      vol_debounce #(.CYCLES(DEBOUNCE_CYCLES)) uDeb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rawLvl   (stepSync),
        .cleanLvl (stepClean)
      );
    end else begin : gBypass
      assign stepClean = stepSync;
    end
  endgenerate

  vol_ctrl uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stepLvl (stepClean),
    .dirLvl  (syncBus[1]),
    .shdnLvl (syncBus[2]),
    .cmd     (cmd)
  );

  vol_datapath #(
    .LEVELS      (LEVELS),
    .STEP_DB     (STEP_DB),
    .MIN_DB      (MIN_DB),
    .DEFAULT_IDX (DEFAULT_IDX),
    .DB_W        (DB_W)
  ) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .gainIdx   (gainIdx),
    .gainDb    (gainDb),
    .outEnable (outEnable)
  );

endmodule

// File: tb/sim_stepped_volume_ctrl.sv
`timescale 1ns/1ps
module sim_stepped_volume_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stepClkIn = 1'b0;
  logic dirIn = 1'b0;
  logic shutdownIn = 1'b0;
  logic [3:0] gainIdx;
  logic signed [6:0] gainDb;
  logic outEnable;

  int checks = 0;
  int fails  = 0;
  int expIdx = 11;

  always #2.5 clk = ~clk;

  stepped_volume_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .stepClkIn  (stepClkIn),
    .dirIn      (dirIn),
    .shutdownIn (shutdownIn),
    .gainIdx    (gainIdx),
    .gainDb     (gainDb),
    .outEnable  (outEnable)
  );

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clean step: direction settles first, strobe held well past the filter
  task automatic pulseStep(input logic up);
    dirIn = up;
    waitCyc(8);
    stepClkIn = 1'b1;
    waitCyc(12);
    stepClkIn = 1'b0;
    waitCyc(12);
    if (!shutdownIn) begin
      if (up && expIdx < 15) expIdx++;
      else if (!up && expIdx > 0) expIdx--;
    end
  endtask

  function automatic int dbOf(input int i);
    return i * 3 - 33;
  endfunction

  task automatic tReset();
    rst_n = 1'b0;
    waitCyc(3);
    chk("R1 index", int'(gainIdx), 11);
    chk("R1 dB", int'(gainDb), 0);
    rst_n = 1'b1;
    waitCyc(6);
    expIdx = 11;
    chk("R1 index after release", int'(gainIdx), 11);
    chk("R8 enable idle", int'(outEnable), 1);
  endtask

  task automatic tUpDown();
    pulseStep(1'b1);
    pulseStep(1'b1);
    chk("R2 up twice", int'(gainIdx), 13);
    chk("R7 dB at 13", int'(gainDb), 6);
    for (int i = 0; i < 3; i++) pulseStep(1'b0);
    chk("R3 down thrice", int'(gainIdx), 10);
    chk("R7 dB at 10", int'(gainDb), -3);
  endtask

  task automatic tLevelOnly();
    dirIn = 1'b1;
    waitCyc(8);
    stepClkIn = 1'b1;
    waitCyc(30);
    chk("R4 long high one step", int'(gainIdx), 11);
    dirIn = 1'b0;
    waitCyc(20);
    dirIn = 1'b1;
    waitCyc(20);
    chk("R4 dir toggle while high", int'(gainIdx), 11);
    stepClkIn = 1'b0;
    waitCyc(20);
    chk("R4 falling edge", int'(gainIdx), 11);
    expIdx = 11;
  endtask

  task automatic tSaturate();
    for (int i = 0; i < 8; i++) pulseStep(1'b1);
    chk("R5 top saturation", int'(gainIdx), 15);
    chk("R7 dB max", int'(gainDb), 12);
    for (int i = 0; i < 20; i++) pulseStep(1'b0);
    chk("R6 bottom saturation", int'(gainIdx), 0);
    chk("R7 dB min", int'(gainDb), -33);
    for (int i = 0; i < 4; i++) pulseStep(1'b1);
    chk("R2 climb from bottom", int'(gainIdx), 4);
    chk("R7 dB at 4", int'(gainDb), dbOf(4));
  endtask

  task automatic tShutdown();
    shutdownIn = 1'b1;
    waitCyc(8);
    chk("R8 muted", int'(outEnable), 0);
    for (int i = 0; i < 3; i++) pulseStep(1'b1);
    chk("R9 frozen in shutdown", int'(gainIdx), 4);
    shutdownIn = 1'b0;
    waitCyc(8);
    chk("R8 enabled again", int'(outEnable), 1);
    chk("R9 setting kept", int'(gainIdx), 4);
    pulseStep(1'b1);
    chk("R9 steps resume", int'(gainIdx), expIdx);
  endtask

  task automatic tGlitch();
    dirIn = 1'b1;
    waitCyc(8);
    stepClkIn = 1'b1;
    waitCyc(2);
    stepClkIn = 1'b0;
    waitCyc(20);
    chk("R11 short glitch rejected", int'(gainIdx), expIdx);
    pulseStep(1'b1);
    chk("R11 long pulse accepted", int'(gainIdx), expIdx);
    chk("R11 long pulse value", int'(gainIdx), 6);
  endtask

  initial begin
    waitCyc(1);
    tReset();
    tUpDown();
    tLevelOnly();
    tSaturate();
    tShutdown();
    tGlitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule